// File: doc/BRIEF.md
# Host-Target Mailbox Console

This block is a small memory-mapped mailbox through which a processor exchanges command words with a host. There are two 64-bit registers. The processor posts a request in the outbound register and receives an answer in the inbound register. The bus is 32 bits wide, so each register is reached as a low half and a high half. The outbound register only takes a new command while it is empty. Writing its upper half commits the command.

A committed command is split into an 8-bit device selector (bits 63:56), an 8-bit command selector (bits 55:48) and a 48-bit payload (bits 47:0). A controller state machine acts on the command:

- It sends console bytes out on a valid/ready stream.
- It parks console read requests until a byte arrives on the receive input.
- It reports program exit through a one-cycle pulse that carries an exit code.

For every request other than a console read, it writes a response into the inbound register and clears the outbound register.

The controller has four states:

- ST_IDLE waits for a commit and moves to ST_DECODE.
- ST_DECODE has three exits. A console read parks the word and returns to ST_IDLE. A console write moves to ST_PUT. Every other command moves to ST_REPLY with an empty response.
- ST_PUT presents the byte and moves to ST_REPLY once it is accepted.
- ST_REPLY writes the inbound register, clears the outbound register and returns to ST_IDLE.

Top module: `hostlink_mbox`

## Requirements
- R1: After reset, every register half reads zero, and tx_valid and exit_pulse are low.
- R2: The register halves are at these byte offsets: inbound low at 0x0, inbound high at 0x4, outbound low at 0x8, outbound high at 0xC. A read returns the selected half on bus_rdata one cycle after the access. Any other offset reads zero, and a write to it changes nothing.
- R3: A write to the outbound low half is accepted only while the outbound register is zero. It loads bits 31:0, clears bits 63:32 and arms a commit flag. While the register is non-zero, such a write is ignored and disarms the flag, so a later high-half write is also ignored.
- R4: A write to the outbound high half while the flag is armed ORs the data into bits 63:32 and starts command handling.
- R5: Device 1, command 1 raises tx_valid with tx_data equal to payload bits 7:0. Both hold steady until tx_ready is high.
- R6: After a console write is accepted, the inbound register becomes {command word bits 63:48, 48-bit response 0x100 OR byte}, and the outbound register reads zero.
- R7: Device 0, command 0 with payload bit 0 set gives exactly one exit_pulse cycle with exit_code equal to payload bits 47:1. The inbound register then becomes {bits 63:48, 48'h0} and the outbound register is cleared.
- R8: Device 1, command 0 clears the outbound register and leaves the inbound register unchanged. A later rx_valid cycle sets the inbound register to {bits 63:48 of that parked word, 0x100 OR rx_data}.
- R9: Any other device/command pair sets the inbound register to {bits 63:48, 48'h0} and clears the outbound register. This includes device 0, command 0 with payload bit 0 clear. No byte is sent and no exit is reported.
- R10: A write to the inbound low half loads bits 31:0 and clears bits 63:32. A write to the inbound high half ORs the data into bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the 32-bit half |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_valid | output | 1 | Console output byte valid |
| tx_ready | input | 1 | Console output byte accepted |
| tx_data | output | 8 | Console output byte |
| rx_valid | input | 1 | Received console byte, one cycle |
| rx_data | input | 8 | Received console byte value |
| exit_pulse | output | 1 | One-cycle exit report |
| exit_code | output | 47 | Exit code, zero means success |

## Verification
The assertions assume that the processor does not write the outbound high half while a command is being handled and the commit flag is still armed. They also assume that rx_valid never coincides with a response write that the bench checks. The stimulus waits a fixed number of cycles after each commit, which covers the whole state sequence. It therefore issues a new command only once the outbound register is empty, and pulses rx_valid only after a console read has been parked. The one deliberate write during a busy period is the ignored low-half write. That write disarms the flag, so the high-half write that follows it cannot restart handling.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;

    localparam int WORD_W    = 64;
    localparam int HALF_W    = 32;
    localparam int FIELD_W   = 8;
    localparam int DEV_LSB   = 56;
    localparam int CMD_LSB   = 48;
    localparam int PAYLOAD_W = 48;
    localparam int CODE_W    = PAYLOAD_W - 1;

    localparam logic [FIELD_W-1:0] DEV_SYS  = 8'd0;
    localparam logic [FIELD_W-1:0] DEV_CON  = 8'd1;
    localparam logic [FIELD_W-1:0] CMD_EXIT = 8'd0;
    localparam logic [FIELD_W-1:0] CMD_GET  = 8'd0;
    localparam logic [FIELD_W-1:0] CMD_PUT  = 8'd1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_PUT,
        ST_REPLY
    } ctrl_state_e;

    function automatic logic [PAYLOAD_W-1:0] char_resp(input logic [7:0] b);
        return {{(PAYLOAD_W-9){1'b0}}, 1'b1, b};
    endfunction

endpackage

// File: rtl/hostlink_regs.sv
module hostlink_regs
    import hostlink_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int FH_OFF = 0,
    parameter int TH_OFF = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [HALF_W-1:0]   bus_wdata,
    output logic [HALF_W-1:0]   bus_rdata,
    input  logic                rx_valid,
    input  logic [7:0]          rx_data,
    input  logic                reply_stb,
    input  logic [WORD_W-1:0]   reply_val,
    input  logic                park_stb,
    output logic [WORD_W-1:0]   to_word,
    output logic                cmd_start
);

    localparam logic [ADDR_W-1:0] A_FL = ADDR_W'(FH_OFF);
    localparam logic [ADDR_W-1:0] A_FH = ADDR_W'(FH_OFF + 4);
    localparam logic [ADDR_W-1:0] A_TL = ADDR_W'(TH_OFF);
    localparam logic [ADDR_W-1:0] A_TH = ADDR_W'(TH_OFF + 4);

    logic [WORD_W-1:0] to_q, fh_q, pend_q;
    logic              allow_q;
    logic              wr, rd, hit_fl, hit_fh, hit_tl, hit_th, any_hit;

    assign wr      = bus_sel && bus_we;
    assign rd      = bus_sel && !bus_we;
    assign hit_fl  = (bus_addr == A_FL);
    assign hit_fh  = (bus_addr == A_FH);
    assign hit_tl  = (bus_addr == A_TL);
    assign hit_th  = (bus_addr == A_TH);
    assign any_hit = hit_fl || hit_fh || hit_tl || hit_th;
    assign to_word = to_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q      <= '0;
            fh_q      <= '0;
            pend_q    <= '0;
            allow_q   <= 1'b0;
            cmd_start <= 1'b0;
            bus_rdata <= '0;
        end else begin
            cmd_start <= 1'b0;
            if (reply_stb || park_stb) begin
                to_q <= '0;
            end else if (wr && hit_tl) begin
                if (to_q == '0) begin
                    to_q    <= {{HALF_W{1'b0}}, bus_wdata};
                    allow_q <= 1'b1;
                end else begin
                    allow_q <= 1'b0;
                end
            end else if (wr && hit_th && allow_q) begin
                to_q[WORD_W-1:HALF_W] <= to_q[WORD_W-1:HALF_W] | bus_wdata;
                cmd_start             <= 1'b1;
            end

            if (park_stb) begin
                pend_q <= to_q;
            end

            if (reply_stb) begin
                fh_q <= reply_val;
            end else if (rx_valid) begin
                fh_q <= {pend_q[WORD_W-1:CMD_LSB], char_resp(rx_data)};
            end else if (wr && hit_fl) begin
                fh_q <= {{HALF_W{1'b0}}, bus_wdata};
            end else if (wr && hit_fh) begin
                fh_q[WORD_W-1:HALF_W] <= fh_q[WORD_W-1:HALF_W] | bus_wdata;
            end

            if (rd) begin
                if (hit_fl)      bus_rdata <= fh_q[HALF_W-1:0];
                else if (hit_fh) bus_rdata <= fh_q[WORD_W-1:HALF_W];
                else if (hit_tl) bus_rdata <= to_q[HALF_W-1:0];
                else if (hit_th) bus_rdata <= to_q[WORD_W-1:HALF_W];
                else             bus_rdata <= '0;
            end
        end
    end

    AST_TOHOST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_tl && (to_q != '0) && !reply_stb && !park_stb) |=> $stable(to_q)); // R3

    AST_HANDLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_stb || park_stb) |=> (to_q == '0)); // R6

    AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !any_hit && !reply_stb && !park_stb && !rx_valid)
            |=> ($stable(to_q) && $stable(fh_q))); // R2

endmodule

// File: rtl/hostlink_ctrl.sv
module hostlink_ctrl
    import hostlink_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [WORD_W-1:0]   to_word,
    input  logic                tx_ready,
    output logic                tx_valid,
    output logic [7:0]          tx_data,
    output logic                exit_pulse,
    output logic [CODE_W-1:0]   exit_code,
    output logic                reply_stb,
    output logic [WORD_W-1:0]   reply_val,
    output logic                park_stb
);

    ctrl_state_e          state_q, state_d;
    logic [WORD_W-1:0]    word_q;
    logic [PAYLOAD_W-1:0] resp_q, resp_d;
    logic [FIELD_W-1:0]   dev, cmd;
    logic                 is_exit, is_get, is_put;

    assign dev     = word_q[WORD_W-1:DEV_LSB];
    assign cmd     = word_q[DEV_LSB-1:CMD_LSB];
    assign is_exit = (dev == DEV_SYS) && (cmd == CMD_EXIT) && word_q[0];
    assign is_get  = (dev == DEV_CON) && (cmd == CMD_GET);
    assign is_put  = (dev == DEV_CON) && (cmd == CMD_PUT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            resp_q  <= '0;
        end else begin
            state_q <= state_d;
            resp_q  <= resp_d;
            if (state_q == ST_IDLE && cmd_start) begin
                word_q <= to_word;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        resp_d  = resp_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = ST_DECODE;
            end
            ST_DECODE: begin
                resp_d = '0;
                if (is_get)      state_d = ST_IDLE;
                else if (is_put) state_d = ST_PUT;
                else             state_d = ST_REPLY;
            end
            ST_PUT: begin
                if (tx_ready) begin
                    state_d = ST_REPLY;
                    resp_d  = char_resp(word_q[7:0]);
                end
            end
            ST_REPLY: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_valid   = (state_q == ST_PUT);
        tx_data    = word_q[7:0];
        exit_pulse = (state_q == ST_DECODE) && is_exit;
        exit_code  = word_q[PAYLOAD_W-1:1];
        park_stb   = (state_q == ST_DECODE) && is_get;
        reply_stb  = (state_q == ST_REPLY);
        reply_val  = {word_q[WORD_W-1:CMD_LSB], resp_q};
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R5

    AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |=> !exit_pulse); // R7

    AST_EXIT_REPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |=> reply_stb); // R7

endmodule

// File: rtl/hostlink_mbox.sv
module hostlink_mbox
    import hostlink_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int FH_OFF = 0,
    parameter int TH_OFF = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [7:0]           tx_data,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    output logic                 exit_pulse,
    output logic [46:0]          exit_code
);

    logic [WORD_W-1:0] to_word, reply_val;
    logic              cmd_start, reply_stb, park_stb;

    hostlink_regs #(
        .ADDR_W (ADDR_W),
        .FH_OFF (FH_OFF),
        .TH_OFF (TH_OFF)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .reply_stb (reply_stb),
        .reply_val (reply_val),
        .park_stb  (park_stb),
        .to_word   (to_word),
        .cmd_start (cmd_start)
    );

    hostlink_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .to_word    (to_word),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .exit_pulse (exit_pulse),
        .exit_code  (exit_code),
        .reply_stb  (reply_stb),
        .reply_val  (reply_val),
        .park_stb   (park_stb)
    );

endmodule

// File: tb/hostlink_mbox_tb_top.sv
module hostlink_mbox_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        exit_pulse;
    logic [46:0] exit_code;

    int n_checks = 0;
    int n_bad = 0;
    int exit_cnt = 0;
    int tx_cnt = 0;
    logic [46:0] last_code = '0;
    logic [7:0]  last_tx = '0;
    logic [63:0] fh_exp = '0;

    always #10 clk = ~clk;

    hostlink_mbox dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .exit_pulse(exit_pulse), .exit_code(exit_code)
    );

    always @(negedge clk) begin
        if (rst_n && exit_pulse) begin
            exit_cnt  = exit_cnt + 1;
            last_code = exit_code;
        end
        if (rst_n && tx_valid && tx_ready) begin
            tx_cnt  = tx_cnt + 1;
            last_tx = tx_data;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read64(input logic [3:0] base, output logic [63:0] v);
        logic [31:0] lo, hi;
        bus_read(base, lo);
        bus_read(base + 4'd4, hi);
        v = {hi, lo};
    endtask

    task automatic issue(input logic [63:0] w);
        bus_write(4'h8, w[31:0]);
        bus_write(4'hC, w[63:32]);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] resp_word(input logic [63:0] w, input logic [47:0] r);
        return {w[63:48], r};
    endfunction

    function automatic logic [47:0] chr(input logic [7:0] b);
        return {39'h0, 1'b1, b};
    endfunction

    task automatic do_put(input logic [63:0] w);
        int t0;
        logic [63:0] v;
        t0 = tx_cnt;
        issue(w);
        wait_cyc(8);
        check("R5 tx count", 64'(tx_cnt - t0), 64'd1);
        check("R5 tx byte", {56'h0, last_tx}, {56'h0, w[7:0]});
        fh_exp = resp_word(w, chr(w[7:0]));
        read64(4'h0, v); check("R6 inbound after put", v, fh_exp);
        read64(4'h8, v); check("R6 outbound cleared", v, 64'h0);
    endtask

    task automatic do_exit(input logic [63:0] w);
        int e0, t0;
        logic [63:0] v;
        e0 = exit_cnt; t0 = tx_cnt;
        issue(w);
        wait_cyc(8);
        check("R7 exit count", 64'(exit_cnt - e0), 64'd1);
        check("R7 exit code", {17'h0, last_code}, {17'h0, w[47:1]});
        check("R7 no tx", 64'(tx_cnt - t0), 64'd0);
        fh_exp = resp_word(w, 48'h0);
        read64(4'h0, v); check("R7 inbound after exit", v, fh_exp);
        read64(4'h8, v); check("R7 outbound cleared", v, 64'h0);
    endtask

    task automatic do_get(input logic [63:0] w, input logic [7:0] b);
        logic [63:0] v;
        issue(w);
        wait_cyc(8);
        read64(4'h8, v); check("R8 outbound cleared", v, 64'h0);
        read64(4'h0, v); check("R8 inbound unchanged", v, fh_exp);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
        fh_exp = resp_word(w, chr(b));
        read64(4'h0, v); check("R8 inbound after rx", v, fh_exp);
    endtask

    task automatic do_other(input logic [63:0] w);
        int e0, t0;
        logic [63:0] v;
        e0 = exit_cnt; t0 = tx_cnt;
        issue(w);
        wait_cyc(8);
        check("R9 no exit", 64'(exit_cnt - e0), 64'd0);
        check("R9 no tx", 64'(tx_cnt - t0), 64'd0);
        fh_exp = resp_word(w, 48'h0);
        read64(4'h0, v); check("R9 inbound zero response", v, fh_exp);
        read64(4'h8, v); check("R9 outbound cleared", v, 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [31:0] r;
        void'($urandom(32'd20240611));
        wait_cyc(4);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 tx_valid", {63'h0, tx_valid}, 64'h0);
        check("R1 exit_pulse", {63'h0, exit_pulse}, 64'h0);
        read64(4'h0, v); check("R1 inbound", v, 64'h0);
        read64(4'h8, v); check("R1 outbound", v, 64'h0);

        // R10 inbound writes: low loads, high ORs
        bus_write(4'h4, 32'hF000_000F);
        bus_write(4'h0, 32'h1234_5678);
        read64(4'h0, v); check("R10 low load clears high", v, 64'h0000_0000_1234_5678);
        bus_write(4'h4, 32'h0A00_0001);
        bus_write(4'h4, 32'h0050_0002);
        read64(4'h0, v); check("R10 high OR", v, 64'h0A50_0003_1234_5678);
        fh_exp = v;

        // R2 unmapped offsets
        bus_write(4'h2, 32'hFFFF_FFFF);
        bus_write(4'hE, 32'hFFFF_FFFF);
        bus_read(4'h6, r); check("R2 unmapped read", {32'h0, r}, 64'h0);
        read64(4'h0, v); check("R2 inbound untouched", v, fh_exp);
        read64(4'h8, v); check("R2 outbound untouched", v, 64'h0);

        // R3/R4/R5 backpressure and lock
        tx_ready = 1'b0;
        issue(64'h0101_0000_0000_0041);
        wait_cyc(6);
        check("R4 committed tx_valid", {63'h0, tx_valid}, 64'h1);
        check("R5 tx data", {56'h0, tx_data}, 64'h41);
        read64(4'h8, v); check("R4 outbound held", v, 64'h0101_0000_0000_0041);
        bus_write(4'h8, 32'hDEAD_BEEF);
        bus_write(4'hC, 32'h0200_0000);
        read64(4'h8, v); check("R3 locked outbound", v, 64'h0101_0000_0000_0041);
        check("R5 still valid", {63'h0, tx_valid}, 64'h1);
        check("R5 data stable", {56'h0, tx_data}, 64'h41);
        tx_ready = 1'b1;
        wait_cyc(6);
        fh_exp = resp_word(64'h0101_0000_0000_0041, chr(8'h41));
        read64(4'h0, v); check("R6 inbound after held put", v, fh_exp);
        read64(4'h8, v); check("R6 outbound cleared", v, 64'h0);

        // directed corners
        do_exit(64'h0000_0000_0000_0001);
        do_exit(64'h0000_FFFF_FFFF_FFFF);
        do_other(64'h0000_0000_0000_1000);
        do_other(64'h0102_0000_0000_0055);
        do_other(64'hFF00_0000_0000_0001);
        do_get(64'h0100_0000_0000_0000, 8'h00);
        do_put(64'h0101_0000_0000_00FF);

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [63:0] w;
            logic [2:0]  kind;
            w    = {$urandom, $urandom};
            kind = 3'($urandom % 4);
            case (kind)
                3'd0: do_put({16'h0101, w[47:0]});
                3'd1: do_exit({16'h0000, w[47:1], 1'b1});
                3'd2: do_get({16'h0100, w[47:0]}, 8'($urandom));
                default: begin
                    if (w[63:56] < 8'd2) w[63:56] = 8'd2 + 8'(w[0]);
                    do_other(w);
                end
            endcase
        end

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule